// File: doc/BRIEF.md
# Fully Associative Tag Store with Rotating Victim Pointer

This block is the lookup half of a fully associative cache. It holds 64 entries, each a valid bit and a tag, for 32-byte blocks. An address has no index field. The low five bits pick a byte within the block, and every bit above them forms the tag. On a lookup, the tag is compared against all valid entries at once. The block then reports, one cycle later, whether a match was found and which entry matched.

A fill command writes a new tag into the entry named by the victim output. Because any block may sit in any entry, no miss is ever caused by two addresses competing for one slot.

The victim entry is chosen by a single rotating pointer. The pointer steps forward in two cases: when a fill uses its entry, and when a lookup hits the entry it currently names. In every other case it stays where it is. This gives a low-cost approximation of least-recently-used replacement without keeping any access history. Data storage and the memory side are handled elsewhere.

Top module: `fa_tag_store`

## Requirements
- R1: After reset, every entry is invalid, `victim_idx` is 0 and `hit` is 0.
- R2: The tag is `addr[31:5]`. Two addresses that differ only in bits 4:0 match the same entry.
- R3: A lookup strobed at a clock edge sets `hit` and `hit_idx` at that edge. The registered result is visible in the following cycle. With no strobe, `hit` is 0. On a miss, `hit_idx` is 0.
- R4: An invalid entry never matches, whatever tag value it holds. For example, address 0 misses after reset.
- R5: A fill stores the tag of `fill_addr` into entry `victim_idx` and marks that entry valid. At the same edge, `victim_idx` moves to the next entry.
- R6: A lookup that hits the entry named by `victim_idx` moves the pointer to the next entry. A hit on any other entry, or a miss, leaves the pointer unchanged.
- R7: Advancing past entry 63 wraps the pointer to entry 0. This applies to both fills and lookup hits.
- R8: When several valid entries hold the same tag, `hit_idx` reports the lowest-numbered one.
- R9: A fill and a lookup in the same cycle give the fill priority. The lookup is reported as a miss, and the pointer advances exactly once.
- R10: Any 64 distinct block addresses can be resident at the same time, and every one of them hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup strobe |
| lkp_addr | input | 32 | Lookup byte address |
| fill_en | input | 1 | Fill command: write the tag into the victim entry |
| fill_addr | input | 32 | Byte address of the block being filled |
| hit | output | 1 | Registered lookup hit |
| hit_idx | output | 6 | Registered matching entry (0 on a miss) |
| victim_idx | output | 6 | Entry that the next fill will replace |

## Verification
The lookup path is exercised with several address patterns, each aimed at a different fault:
- Addresses that share a tag but differ in the byte-offset bits show whether those bits are wrongly compared.
- Address 0 right after reset shows whether invalid entries leak through the compare.
- Tags one block apart show that neighbouring blocks are kept distinct.
- A duplicated tag shows the priority order.

Victim tracking is checked in three ways:
- Hits on the pointed entry are compared with hits on other entries, which tells a correct pointer move apart from one that moves on every hit.
- A full pass of 64 fills, followed by a sweep of lookup hits, drives the pointer through its wrap both ways.
- A fill that overlaps a lookup confirms that the lookup is suppressed and that the overwritten tag is gone.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int FA_ADDR_W   = 32;
  localparam int FA_OFFSET_W = 5;
  localparam int FA_ENTRIES  = 64;

  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_LOOKUP = 2'd1,
    ACT_FILL   = 2'd2
  } fa_act_e;
endpackage

// File: rtl/fa_tag_array.sv
module fa_tag_array #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 27,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [TAG_W-1:0]   cmp_tag,
  output logic [ENTRIES-1:0] match
);
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  // Tag storage carries no reset; validity is tracked separately.
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  // One comparator per entry, qualified by its valid bit.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag_mem[g] == cmp_tag);
  end

  assert_fill_writes_entry_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld[$past(wr_idx)] && (tag_mem[$past(wr_idx)] == $past(wr_tag)));

  assert_reset_clears_valid_R1: assert property (@(posedge clk)
    rst |=> (vld == '0));
endmodule

// File: rtl/fa_prio_enc.sv
module fa_prio_enc #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] below;

  // Scan from the top down so the lowest set bit is the last one written.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |req;
  assign below = (N'(1) << idx) - N'(1);

  always_comb begin
    if (any) begin
      assert_lowest_wins_R8: assert (req[idx] && ((req & below) == '0));
    end
  end
endmodule

// File: rtl/fa_repl_ptr.sv
module fa_repl_ptr #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_inc;
  logic             step;

  assign ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign step    = fill || (touch && (touch_idx == ptr));

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (step) ptr <= ptr_inc;
  end

  assert_reset_ptr_zero_R1: assert property (@(posedge clk)
    rst |=> (ptr == '0));

  assert_step_at_most_one_R6: assert property (@(posedge clk) disable iff (rst)
    (ptr == $past(ptr)) ||
    (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

  assert_other_hit_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!fill && (!touch || (touch_idx != ptr))) |=> $stable(ptr));

  assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (fill && (ptr == LAST)) |=> (ptr == '0));
endmodule

// File: rtl/fa_tag_store.sv
module fa_tag_store
  import fa_pkg::*;
#(
  parameter int ADDR_W   = FA_ADDR_W,
  parameter int OFFSET_W = FA_OFFSET_W,
  parameter int ENTRIES  = FA_ENTRIES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       lkp_valid,
  input  logic [ADDR_W-1:0]          lkp_addr,
  input  logic                       fill_en,
  input  logic [ADDR_W-1:0]          fill_addr,
  output logic                       hit,
  output logic [$clog2(ENTRIES)-1:0] hit_idx,
  output logic [$clog2(ENTRIES)-1:0] victim_idx
);
  localparam int TAG_W = ADDR_W - OFFSET_W;
  localparam int IDX_W = $clog2(ENTRIES);

  fa_act_e            act;
  logic [ENTRIES-1:0] match;
  logic               any_match;
  logic [IDX_W-1:0]   enc_idx;
  logic               lkp_hit;
  logic [IDX_W-1:0]   ptr;

  // A fill wins over a lookup in the same cycle.
  always_comb begin
    if (fill_en)        act = ACT_FILL;
    else if (lkp_valid) act = ACT_LOOKUP;
    else                act = ACT_IDLE;
  end

  fa_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (act == ACT_FILL),
    .wr_idx  (ptr),
    .wr_tag  (fill_addr[ADDR_W-1:OFFSET_W]),
    .cmp_tag (lkp_addr[ADDR_W-1:OFFSET_W]),
    .match   (match)
  );

  fa_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc (
    .req (match),
    .any (any_match),
    .idx (enc_idx)
  );

  assign lkp_hit = (act == ACT_LOOKUP) && any_match;

  fa_repl_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .fill      (act == ACT_FILL),
    .touch     (lkp_hit),
    .touch_idx (enc_idx),
    .ptr       (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit     <= 1'b0;
      hit_idx <= '0;
    end else begin
      hit     <= lkp_hit;
      hit_idx <= lkp_hit ? enc_idx : '0;
    end
  end

  assign victim_idx = ptr;

  assert_fill_masks_lookup_R9: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> !hit);

  assert_no_strobe_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> !hit);

  assert_miss_idx_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_idx == '0));

  assert_fill_moves_victim_R5: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (victim_idx != $past(victim_idx)));
endmodule

// File: tb/tb_fa_tag_store.sv
`timescale 1ns/1ps
module tb_fa_tag_store;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_addr = '0;
  logic        fill_en = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        hit;
  logic [5:0]  hit_idx;
  logic [5:0]  victim_idx;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fa_tag_store dut (
    .clk        (clk),
    .rst        (rst),
    .lkp_valid  (lkp_valid),
    .lkp_addr   (lkp_addr),
    .fill_en    (fill_en),
    .fill_addr  (fill_addr),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .victim_idx (victim_idx)
  );

  // Row layout: op[46:45] (0 lookup, 1 fill, 2 idle), addr[44:13],
  // expected hit[12], expected hit_idx[11:6], expected victim_idx[5:0].
  localparam int NV = 13;
  localparam logic [46:0] TBL [0:NV-1] = '{
    {2'd1, 32'h0000_1000, 1'b0, 6'd0, 6'd1},  // R5 fill into entry 0
    {2'd1, 32'h0000_2040, 1'b0, 6'd0, 6'd2},  // R5 fill into entry 1
    {2'd1, 32'hABCD_E000, 1'b0, 6'd0, 6'd3},  // R5 fill into entry 2
    {2'd0, 32'h0000_1000, 1'b1, 6'd0, 6'd3},  // R6 hit off-pointer, no move
    {2'd0, 32'h0000_205F, 1'b1, 6'd1, 6'd3},  // R2 offset bits ignored
    {2'd0, 32'hABCD_E01C, 1'b1, 6'd2, 6'd3},  // R2 offset bits ignored
    {2'd0, 32'h0000_0000, 1'b0, 6'd0, 6'd3},  // R4 invalid entries never match
    {2'd0, 32'h0000_1020, 1'b0, 6'd0, 6'd3},  // R2 neighbouring block misses
    {2'd2, 32'h0000_1000, 1'b0, 6'd0, 6'd3},  // R3 no strobe, no hit
    {2'd1, 32'h0000_1000, 1'b0, 6'd0, 6'd4},  // R8 duplicate tag into entry 3
    {2'd0, 32'h0000_1010, 1'b1, 6'd0, 6'd4},  // R8 lowest duplicate wins
    {2'd1, 32'h0000_3000, 1'b0, 6'd0, 6'd5},  // R5 fill into entry 4
    {2'd0, 32'h0000_3000, 1'b1, 6'd4, 6'd5}   // R3 hit index reported
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Drive one cycle of stimulus on a falling edge; return on the next falling
  // edge, after the registered outputs have taken the result.
  task automatic step(input logic lv, input logic [31:0] la,
                      input logic fe, input logic [31:0] fa);
    @(negedge clk);
    lkp_valid = lv;
    lkp_addr  = la;
    fill_en   = fe;
    fill_addr = fa;
    @(negedge clk);
    lkp_valid = 1'b0;
    fill_en   = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] addr_of(input int i);
    return (32'(i + 1) << 12) | 32'(i % 32);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] vic;

    do_reset();
    chk("R1 hit after reset", 32'(hit), 32'd0);
    chk("R1 victim after reset", 32'(victim_idx), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [31:0] a;
      op = TBL[i][46:45];
      a  = TBL[i][44:13];
      step(op == 2'd0, a, op == 2'd1, a);
      chk("R3 table hit", 32'(hit), 32'(TBL[i][12]));
      chk("R3 table hit_idx", 32'(hit_idx), 32'(TBL[i][11:6]));
      chk("R5 table victim", 32'(victim_idx), 32'(TBL[i][5:0]));
    end

    // R10 / R7: 64 distinct blocks fill every entry; the pointer wraps to 0.
    do_reset();
    for (int i = 0; i < 64; i++) begin
      step(1'b0, '0, 1'b1, addr_of(i));
      chk("R7 victim during fill pass", 32'(victim_idx), 32'((i + 1) % 64));
    end

    // R6: a hit elsewhere leaves the pointer; a hit on it advances it.
    step(1'b1, addr_of(5), 1'b0, '0);
    chk("R6 hit idx 5", 32'(hit_idx), 32'd5);
    chk("R6 pointer holds", 32'(victim_idx), 32'd0);
    step(1'b1, addr_of(0), 1'b0, '0);
    chk("R6 hit on pointer", 32'(hit), 32'd1);
    chk("R6 pointer advances", 32'(victim_idx), 32'd1);
    step(1'b1, 32'h8000_0000, 1'b0, '0);
    chk("R6 miss hit", 32'(hit), 32'd0);
    chk("R6 miss holds pointer", 32'(victim_idx), 32'd1);

    // R9: a fill and a lookup of the pointed entry in the same cycle.
    step(1'b1, addr_of(1), 1'b1, 32'hFFFF_F000);
    chk("R9 lookup masked", 32'(hit), 32'd0);
    chk("R9 single advance", 32'(victim_idx), 32'd2);
    step(1'b1, addr_of(1), 1'b0, '0);
    chk("R9 old tag gone", 32'(hit), 32'd0);
    step(1'b1, 32'hFFFF_F01F, 1'b0, '0);
    chk("R9 new tag hit", 32'(hit), 32'd1);
    chk("R9 new tag idx", 32'(hit_idx), 32'd1);

    // R10: every remaining block still resident; each hit chases the pointer.
    vic = 6'd2;
    for (int i = 2; i < 64; i++) begin
      step(1'b1, addr_of(i), 1'b0, '0);
      if (vic == 6'(i)) vic = vic + 6'd1;
      chk("R10 resident hit", 32'(hit), 32'd1);
      chk("R10 resident idx", 32'(hit_idx), 32'(i));
      chk("R6 victim tracking", 32'(victim_idx), 32'(vic));
    end
    chk("R7 wrap by lookup", 32'(victim_idx), 32'd0);

    // R3: a matching address without the strobe.
    step(1'b0, addr_of(3), 1'b0, '0);
    chk("R3 idle no hit", 32'(hit), 32'd0);

    // R1: reset in mid-run invalidates everything.
    do_reset();
    chk("R1 victim after second reset", 32'(victim_idx), 32'd0);
    step(1'b1, addr_of(3), 1'b0, '0);
    chk("R1 entries invalid", 32'(hit), 32'd0);
    chk("R4 miss idx zero", 32'(hit_idx), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule